// File: doc/BRIEF.md
# Transmit Buffer Write Port

This block is the processor-facing path into an 8 KB transmit region of packet memory. Software first programs a write pointer, an optional gap (a start address and a length in halfwords), and a countdown of expected halfwords. It then streams halfwords through a single data register. Each halfword goes straight to the memory write port at the current pointer, in the same cycle as the bus strobe. After each store the pointer moves forward by two bytes. When it lands on the gap address, it jumps over the gap. It always stays inside the 8 KB window.

A countdown register tracks how many halfwords remain. The write that takes it from one to zero raises a one-cycle interrupt pulse. The block also holds six transmit slot descriptor registers. A write-only slot reset command clears the valid flag (bit 15) of any chosen subset of them in a single write. Frame transmission is outside this block.

Top module: `txw_port`

## Requirements
- R1: After reset every register reads zero, `irq_cnt_done` is low and `ram_we` is low.
- R2: Register offsets on `bus_addr` are: 0 write pointer, 1 gap address, 2 gap size, 3 countdown, 4 data, 5 slot reset. A write to the pointer or the gap address keeps `bus_wdata & 0x1FFE`. A write to the gap size or the countdown keeps `bus_wdata & 0x0FFF`. All four read back the kept value.
- R3: A write to offset 4 drives `ram_we` high in that same cycle, with `ram_addr` equal to the current pointer and `ram_wdata` equal to `bus_wdata`. `ram_we` is low in every other cycle.
- R4: After a data write the pointer reads back as the old pointer plus 2, unless R5 applies.
- R5: If the old pointer plus 2 equals the gap address, the new pointer is that value plus twice the gap size.
- R6: The pointer wraps modulo 0x2000. The gap comparison uses the unwrapped value, so stepping from 0x1FFE gives 0x2000 and never matches a gap address of 0. A gap skip that passes 0x2000 wraps to the low end.
- R7: A nonzero countdown decreases by one on each data write. The write that brings it to zero makes `irq_cnt_done` high for exactly the following cycle.
- R8: With the countdown at zero, a data write leaves it at zero and raises no interrupt.
- R9: Offsets 8 to 13 are the slot registers, read/write over 16 bits, in this order: location 1, command, location 2, location 3, reply 2, reply 1. In a write to offset 5, bit 0 clears bit 15 of location 1, bit 1 of command, bit 2 of location 2, bit 3 of location 3, bit 6 of reply 2 and bit 7 of reply 1. All other slot bits are kept.
- R10: In a slot reset write, bits 4, 5 and 8 to 15 have no effect. Slots whose bit is clear are left unchanged.
- R11: Offsets 4 and 5 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ram_we | output | 1 | Packet memory write enable |
| ram_addr | output | 13 | Packet memory byte address (always even) |
| ram_wdata | output | 16 | Packet memory halfword |
| irq_cnt_done | output | 1 | One-cycle pulse when the countdown reaches zero |

## Verification
The bench targets the end of the 8 KB window with a gap address of zero. A design that compares the gap after wrapping would jump past zero instead of landing on it. It also runs a gap skip that crosses the top of the window; a design without the modulo would write outside it. The countdown is driven through the 1-to-0 transition and then held at zero. This exposes a pulse on the wrong cycle, a missing pulse, or an underflow to 0xFFF that fires again later. Slot reset commands use each mapped bit, the unmapped bits 4 and 5, and the high byte. Swapping the two reply slots, clearing whole registers, or honouring unmapped bits then shows up as a wrong read-back value.

// File: rtl/txw_pkg.sv
package txw_pkg;
   localparam int REG_AW     = 4;
   localparam int SLOT_COUNT = 6;

   localparam logic [REG_AW-1:0] RA_PTR       = 4'd0;
   localparam logic [REG_AW-1:0] RA_GAP_ADDR  = 4'd1;
   localparam logic [REG_AW-1:0] RA_GAP_SIZE  = 4'd2;
   localparam logic [REG_AW-1:0] RA_COUNT     = 4'd3;
   localparam logic [REG_AW-1:0] RA_DATA      = 4'd4;
   localparam logic [REG_AW-1:0] RA_SLOT_CLR  = 4'd5;
   localparam logic [REG_AW-1:0] RA_SLOT_BASE = 4'd8;

   // command bit that clears the valid flag of each slot, by slot index
   function automatic int slot_clr_bit(input int idx);
      case (idx)
         4:       return 6;
         5:       return 7;
         default: return idx;
      endcase
   endfunction
endpackage

// File: rtl/txw_ptr_unit.sv
module txw_ptr_unit #(
   parameter int ADDR_W = 13,
   parameter int GAP_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_ptr,
   input  logic              ld_gap_addr,
   input  logic              ld_gap_size,
   input  logic [ADDR_W-1:0] ld_addr_val,
   input  logic [GAP_W-1:0]  ld_size_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] gap_addr,
   output logic [GAP_W-1:0]  gap_size
);
   localparam logic [ADDR_W:0]   STEP_BYTES = (ADDR_W+1)'(2);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic [ADDR_W:0]   raw_sum;
   logic              gap_hit;
   logic [ADDR_W-1:0] adv;
   logic [ADDR_W-1:0] ptr_next;

   always_comb begin
      raw_sum  = {1'b0, ptr} + STEP_BYTES;
      gap_hit  = (raw_sum == {1'b0, gap_addr});
      adv      = gap_hit ? raw_sum[ADDR_W-1:0] + ADDR_W'({gap_size, 1'b0})
                         : raw_sum[ADDR_W-1:0];
      ptr_next = adv & ALIGN_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr      <= '0;
         gap_addr <= '0;
         gap_size <= '0;
      end else begin
         if (ld_ptr)           ptr <= ld_addr_val & ALIGN_MASK;
         else if (step)        ptr <= ptr_next;
         if (ld_gap_addr) gap_addr <= ld_addr_val & ALIGN_MASK;
         if (ld_gap_size) gap_size <= ld_size_val;
      end
   end
endmodule

// File: rtl/txw_countdown.sv
module txw_countdown #(
   parameter int CNT_W   = 12,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic last_step;
   assign last_step = step && (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)                   count <= '0;
      else if (load)                count <= load_val;
      else if (step && count != '0) count <= count - ONE;
   end

   generate
      if (IRQ_REG) begin : g_reg_irq
         logic done_q;
         always_ff @(posedge clk) begin
            if (!rst_n) done_q <= 1'b0;
            else        done_q <= last_step;
         end
         assign done = done_q;
      end else begin : g_comb_irq
         assign done = last_step;
      end
   endgenerate
endmodule

// File: rtl/txw_slot_bank.sv
module txw_slot_bank
   import txw_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int VALID_BIT = 15
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [$clog2(SLOT_COUNT)-1:0]    wr_idx,
   input  logic [DATA_W-1:0]                wr_val,
   input  logic                             clr_en,
   input  logic [DATA_W-1:0]                clr_cmd,
   output logic [SLOT_COUNT-1:0][DATA_W-1:0] slots
);
   generate
      for (genvar i = 0; i < SLOT_COUNT; i++) begin : g_slot
         localparam int CBIT = slot_clr_bit(i);
         always_ff @(posedge clk) begin
            if (!rst_n)
               slots[i] <= '0;
            else if (wr_en && wr_idx == ($clog2(SLOT_COUNT))'(i))
               slots[i] <= wr_val;
            else if (clr_en && clr_cmd[CBIT])
               slots[i][VALID_BIT] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/txw_port.sv
module txw_port
   import txw_pkg::*;
#(
   parameter int  ADDR_W    = 13,
   parameter int  CNT_W     = 12,
   parameter int  DATA_W    = 16,
   parameter int  VALID_BIT = 15,
   parameter bit  IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [3:0]        bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              ram_we,
   output logic [12:0]       ram_addr,
   output logic [15:0]       ram_wdata,
   output logic              irq_cnt_done
);
   localparam int SIDX_W = $clog2(SLOT_COUNT);

   generate
      if (CNT_W + 1 > ADDR_W) begin : g_bad_cnt
         $error("gap size times two must fit the address width");
      end
      if (DATA_W != 16 || ADDR_W != 13) begin : g_bad_port
         $error("port widths fixed at 16-bit data and 13-bit address");
      end
      if (VALID_BIT >= DATA_W || slot_clr_bit(SLOT_COUNT-1) >= DATA_W) begin : g_bad_bit
         $error("slot flag or command bit outside data width");
      end
      if (REG_AW != 4) begin : g_bad_aw
         $error("register offset width must be 4");
      end
   endgenerate

   // decode
   logic wr_ptr, wr_gap_addr, wr_gap_size, wr_cnt, wr_data, wr_clr, wr_slot;
   logic in_slot_rng;
   logic [SIDX_W-1:0] slot_idx;

   always_comb begin
      in_slot_rng = (bus_addr >= RA_SLOT_BASE) &&
                    (bus_addr <  RA_SLOT_BASE + REG_AW'(SLOT_COUNT));
      slot_idx    = SIDX_W'(bus_addr - RA_SLOT_BASE);
      wr_ptr      = bus_wr && bus_addr == RA_PTR;
      wr_gap_addr = bus_wr && bus_addr == RA_GAP_ADDR;
      wr_gap_size = bus_wr && bus_addr == RA_GAP_SIZE;
      wr_cnt      = bus_wr && bus_addr == RA_COUNT;
      wr_data     = bus_wr && bus_addr == RA_DATA;
      wr_clr      = bus_wr && bus_addr == RA_SLOT_CLR;
      wr_slot     = bus_wr && in_slot_rng;
   end

   logic [ADDR_W-1:0] wptr_q;
   logic [ADDR_W-1:0] gap_addr_q;
   logic [CNT_W-1:0]  gap_size_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SLOT_COUNT-1:0][DATA_W-1:0] slot_q;

   txw_ptr_unit #(.ADDR_W(ADDR_W), .GAP_W(CNT_W)) i_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_ptr      (wr_ptr),
      .ld_gap_addr (wr_gap_addr),
      .ld_gap_size (wr_gap_size),
      .ld_addr_val (bus_wdata[ADDR_W-1:0]),
      .ld_size_val (bus_wdata[CNT_W-1:0]),
      .step        (wr_data),
      .ptr         (wptr_q),
      .gap_addr    (gap_addr_q),
      .gap_size    (gap_size_q)
   );

   txw_countdown #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_cnt),
      .load_val (bus_wdata[CNT_W-1:0]),
      .step     (wr_data),
      .count    (cnt_q),
      .done     (irq_cnt_done)
   );

   txw_slot_bank #(.DATA_W(DATA_W), .VALID_BIT(VALID_BIT)) i_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_slot),
      .wr_idx  (slot_idx),
      .wr_val  (bus_wdata),
      .clr_en  (wr_clr),
      .clr_cmd (bus_wdata),
      .slots   (slot_q)
   );

   // memory side follows the strobe in the same cycle
   assign ram_we    = wr_data;
   assign ram_addr  = wptr_q;
   assign ram_wdata = bus_wdata;

   // read mux; data and slot reset offsets fall through to zero
   always_comb begin
      bus_rdata = '0;
      if (in_slot_rng) begin
         bus_rdata = slot_q[slot_idx];
      end else begin
         case (bus_addr)
            RA_PTR:      bus_rdata = DATA_W'(wptr_q);
            RA_GAP_ADDR: bus_rdata = DATA_W'(gap_addr_q);
            RA_GAP_SIZE: bus_rdata = DATA_W'(gap_size_q);
            RA_COUNT:    bus_rdata = DATA_W'(cnt_q);
            default:     bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/txw_port_chk.sv
module txw_port_chk
   import txw_pkg::*;
#(
   parameter int ADDR_W  = 13,
   parameter int CNT_W   = 12,
   parameter bit IRQ_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [3:0]        bus_addr,
   input logic [15:0]       bus_rdata,
   input logic              ram_we,
   input logic [12:0]       ram_addr,
   input logic              irq,
   input logic [ADDR_W-1:0] ptr,
   input logic [CNT_W-1:0]  cnt
);
   // R3
   ram_addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_addr[0] == 1'b0);

   // R4
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(ptr));

   // R8
   cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && cnt == '0) |=> cnt == '0);

   // R7
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R11
   wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_DATA || bus_addr == RA_SLOT_CLR) |-> bus_rdata == 16'h0000);

   generate
      if (IRQ_REG) begin : g_reg
         // R7
         irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(ram_we) && cnt == '0);
      end else begin : g_comb
         // R7
         irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> ram_we);
      end
   endgenerate
endmodule

bind txw_port txw_port_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .ram_we    (ram_we),
   .ram_addr  (ram_addr),
   .irq       (irq_cnt_done),
   .ptr       (wptr_q),
   .cnt       (cnt_q)
);

// File: tb/test_txw_port.sv
module test_txw_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'd0;
   logic [15:0] bus_wdata = 16'h0;
   logic [15:0] bus_rdata;
   logic        ram_we;
   logic [12:0] ram_addr;
   logic [15:0] ram_wdata;
   logic        irq_cnt_done;

   int checks = 0;
   int failures = 0;
   logic        s_we, s_irq;
   logic [12:0] s_addr;
   logic [15:0] s_wdata;

   always #5 clk = ~clk;

   txw_port i_txw_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .irq_cnt_done(irq_cnt_done)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1;
      s_we = ram_we; s_addr = ram_addr; s_wdata = ram_wdata;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
      s_irq = irq_cnt_done;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
      logic [15:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic data_chk(input string req, input logic [15:0] d, input logic [12:0] exp_addr);
      wr(4'd4, d);
      check({req, " ram_we"}, {15'd0, s_we}, 16'd1);
      check({req, " ram_addr"}, {3'd0, s_addr}, {3'd0, exp_addr});
      check({req, " ram_wdata"}, s_wdata, d);
   endtask

   task automatic t_reset;
      for (int a = 0; a < 16; a++) rd_chk("R1 reg", a[3:0], 16'h0);
      check("R1 irq", {15'd0, irq_cnt_done}, 16'd0);
      check("R1 ram_we", {15'd0, ram_we}, 16'd0);
   endtask

   task automatic t_masks;
      wr(4'd0, 16'hFFFF); rd_chk("R2 ptr mask", 4'd0, 16'h1FFE);
      wr(4'd0, 16'h2345); rd_chk("R2 ptr mask2", 4'd0, 16'h0344);
      wr(4'd1, 16'hFFFF); rd_chk("R2 gap addr mask", 4'd1, 16'h1FFE);
      wr(4'd2, 16'hFFFF); rd_chk("R2 gap size mask", 4'd2, 16'h0FFF);
      wr(4'd3, 16'hF123); rd_chk("R2 count mask", 4'd3, 16'h0123);
      wr(4'd3, 16'h0000);
      check("R3 no ram_we on reg write", {15'd0, s_we}, 16'd0);
   endtask

   task automatic t_seq;
      wr(4'd0, 16'h0100); wr(4'd1, 16'h1F00); wr(4'd2, 16'h0000);
      data_chk("R3 seq0", 16'hA001, 13'h0100);
      data_chk("R3 seq1", 16'hA002, 13'h0102);
      data_chk("R4 seq2", 16'hA003, 13'h0104);
      rd_chk("R4 ptr after", 4'd0, 16'h0106);
   endtask

   task automatic t_gap;
      wr(4'd0, 16'h0200); wr(4'd1, 16'h0204); wr(4'd2, 16'h0010);
      data_chk("R5 pre0", 16'h1111, 13'h0200);
      data_chk("R5 pre1", 16'h2222, 13'h0202);
      rd_chk("R5 skipped ptr", 4'd0, 16'h0224);
      data_chk("R5 after gap", 16'h3333, 13'h0224);
   endtask

   task automatic t_wrap;
      wr(4'd0, 16'h1FFC); wr(4'd1, 16'h0000); wr(4'd2, 16'h0005);
      data_chk("R6 top-1", 16'h4444, 13'h1FFC);
      data_chk("R6 top", 16'h5555, 13'h1FFE);
      rd_chk("R6 wrap no skip", 4'd0, 16'h0000);
      wr(4'd0, 16'h1FF0); wr(4'd1, 16'h1FF2); wr(4'd2, 16'h0010);
      data_chk("R6 skip cross", 16'h6666, 13'h1FF0);
      rd_chk("R6 skip wrapped", 4'd0, 16'h0012);
   endtask

   task automatic t_count;
      wr(4'd3, 16'h0003);
      wr(4'd4, 16'h0001); check("R7 no irq at 2", {15'd0, s_irq}, 16'd0);
      rd_chk("R7 count 2", 4'd3, 16'h0002);
      wr(4'd4, 16'h0002); check("R7 no irq at 1", {15'd0, s_irq}, 16'd0);
      wr(4'd4, 16'h0003); check("R7 irq at 0", {15'd0, s_irq}, 16'd1);
      @(posedge clk); #1;
      check("R7 irq one cycle", {15'd0, irq_cnt_done}, 16'd0);
      rd_chk("R7 count 0", 4'd3, 16'h0000);
   endtask

   task automatic t_count_zero;
      wr(4'd4, 16'h0004); check("R8 no irq at zero", {15'd0, s_irq}, 16'd0);
      rd_chk("R8 count stays 0", 4'd3, 16'h0000);
      wr(4'd4, 16'h0005); check("R8 no irq again", {15'd0, s_irq}, 16'd0);
      rd_chk("R8 count still 0", 4'd3, 16'h0000);
   endtask

   function automatic logic [15:0] sv(input int i);
      return 16'h8000 | (16'h0111 * 16'(i + 1));
   endfunction

   task automatic t_slots;
      for (int i = 0; i < 6; i++) wr(4'(8 + i), sv(i));
      for (int i = 0; i < 6; i++) rd_chk("R9 slot rw", 4'(8 + i), sv(i));
      wr(4'd5, 16'h0005);
      rd_chk("R9 loc1 cleared", 4'd8, sv(0) & 16'h7FFF);
      rd_chk("R10 cmd kept", 4'd9, sv(1));
      rd_chk("R9 loc2 cleared", 4'd10, sv(2) & 16'h7FFF);
      rd_chk("R10 loc3 kept", 4'd11, sv(3));
      wr(4'd5, 16'hFF30);
      for (int i = 0; i < 6; i++)
         rd_chk("R10 unmapped bits", 4'(8 + i), (i == 0 || i == 2) ? (sv(i) & 16'h7FFF) : sv(i));
      wr(4'd5, 16'h0040);
      rd_chk("R9 reply2 cleared", 4'd12, sv(4) & 16'h7FFF);
      rd_chk("R10 reply1 kept", 4'd13, sv(5));
      wr(4'd5, 16'h0080);
      rd_chk("R9 reply1 cleared", 4'd13, sv(5) & 16'h7FFF);
      wr(4'd5, 16'h000A);
      rd_chk("R9 cmd cleared", 4'd9, sv(1) & 16'h7FFF);
      rd_chk("R9 loc3 cleared", 4'd11, sv(3) & 16'h7FFF);
   endtask

   task automatic t_wo_reads;
      wr(4'd5, 16'hFFFF);
      rd_chk("R11 slot reset reads 0", 4'd5, 16'h0000);
      wr(4'd4, 16'hBEEF);
      rd_chk("R11 data reads 0", 4'd4, 16'h0000);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset;
      t_masks;
      t_seq;
      t_gap;
      t_wrap;
      t_count;
      t_count_zero;
      t_slots;
      t_wo_reads;
      repeat (2) @(posedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule